// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block gathers up to 32 interrupt inputs into a status register, masks them with a per-input enable, and drives one registered interrupt request toward a processor. Each input is fixed at build time as edge-sensitive (latched on a rising edge) or level-sensitive (latched on every cycle it is high), chosen by a kind-mask parameter.

Software reaches it through a small word-addressed register bus with a one-cycle read latency. It can replace the whole enable mask, or set and clear single enable bits atomically with no read-modify-write. It acknowledges requests with write-one-to-clear, and reads a vector register that names the lowest-numbered pending enabled input. A two-bit master control gates the request output.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, status, enable and master control are zero, the request output is low, and a read of the vector word returns 0xFFFFFFFF.
- R2: Word addresses are 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. Acknowledge, set-enable and clear-enable read as zero; pending reads as status AND enable; bits at or above NUM_IN read as zero.
- R3: Writing the set-enable word sets each enable bit whose data bit is 1 and leaves the others unchanged.
- R4: Writing the clear-enable word clears each enable bit whose data bit is 1 and leaves the others unchanged.
- R5: Writing the enable word replaces all enable bits; writing zero disables every input, and data bits at or above NUM_IN are dropped.
- R6: Writing the acknowledge word clears each status bit whose data bit is 1; a new request in the same cycle wins over the clear.
- R7: The vector word reads the index of the lowest-numbered bit of status AND enable, or 0xFFFFFFFF when that is zero.
- R8: An input whose KIND_MASK bit is 1 sets its status bit only on a rising edge against its registered previous value; holding it high after an acknowledge does not set it again.
- R9: An input whose KIND_MASK bit is 0 sets its status bit on every cycle it is high, so it reappears after an acknowledge while still asserted.
- R10: The request output is registered: one cycle after master bit 0 and bit 1 are both 1 and status AND enable is non-zero, it is high, and otherwise low.
- R11: Read data is registered: it shows the word selected by the address presented one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | NUM_IN | Interrupt inputs |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume the interrupt inputs are already synchronous to the clock and that only one register write is presented per cycle, which the bus shape guarantees. They also assume inputs are low while reset is released, so no edge input sees a spurious rise against its cleared history. The stimulus changes inputs and bus signals only on the falling clock edge, holds inputs low through reset, and pulses edge inputs for single cycles or holds them high deliberately where re-triggering is under test.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    W_STATUS  = 3'd0,
    W_PENDING = 3'd1,
    W_ENABLE  = 3'd2,
    W_ACK     = 3'd3,
    W_SETEN   = 3'd4,
    W_CLREN   = 3'd5,
    W_VECTOR  = 3'd6,
    W_MASTER  = 3'd7
  } reg_word_e;
endpackage

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter int          NUM_IN    = 8,
  parameter logic [31:0] KIND_MASK = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] src,
  output logic [NUM_IN-1:0] hit
);
  logic [NUM_IN-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= src;
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    if (KIND_MASK[i]) begin : g_edge
      assign hit[i] = src[i] & ~prev_q[i];
    end else begin : g_level
      assign hit[i] = src[i];
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int          NUM_IN    = 8,
  parameter logic [31:0] KIND_MASK = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_IN-1:0] hit,
  output logic [NUM_IN-1:0] status,
  output logic [NUM_IN-1:0] enable,
  output logic [1:0]        master
);
  logic [NUM_IN-1:0] wbits, ack_m;

  assign wbits = wdata[NUM_IN-1:0];
  assign ack_m = (wr && addr == W_ACK) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      master <= '0;
    end else begin
      status <= (status & ~ack_m) | hit;
      if (wr) begin
        case (addr)
          W_ENABLE: enable <= wbits;
          W_SETEN:  enable <= enable | wbits;
          W_CLREN:  enable <= enable & ~wbits;
          W_MASTER: master <= wdata[1:0];
          default:  ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
    // R3
    set_en_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && addr == W_SETEN && wdata[i]) |=> enable[i]);
    // R4
    clr_en_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && addr == W_CLREN && wdata[i]) |=> !enable[i]);
    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && addr == W_ACK && wdata[i] && !hit[i]) |=> !status[i]);
    if (KIND_MASK[i]) begin : g_e
      // R8
      edge_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[i]) |-> $past(hit[i]));
    end else begin : g_l
      // R9
      level_refire_chk: assert property (@(posedge clk) disable iff (rst)
        hit[i] |=> status[i]);
    end
  end
endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc
  import irq_pkg::*;
#(
  parameter int NUM_IN = 8
) (
  input  logic [NUM_IN-1:0] pend,
  output logic [DATA_W-1:0] vec
);
  always_comb begin
    vec = '1;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pend[i]) vec = DATA_W'(i);
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int          NUM_IN    = 8,
  parameter logic [31:0] KIND_MASK = 32'h0000_00F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_IN-1:0] irq_src,
  output logic              irq_req
);
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [NUM_IN-1:0] hit, status, enable, pend;
  logic [1:0]        master;
  logic [DATA_W-1:0] vec, rd_mux;

  irq_sense #(.NUM_IN(NUM_IN), .KIND_MASK(KIND_MASK)) u_sense (
    .clk(clk), .rst(rst), .src(irq_src), .hit(hit));

  irq_regs #(.NUM_IN(NUM_IN), .KIND_MASK(KIND_MASK)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .hit(hit), .status(status), .enable(enable), .master(master));

  assign pend = status & enable;

  irq_vec_enc #(.NUM_IN(NUM_IN)) u_enc (.pend(pend), .vec(vec));

  always_comb begin
    case (bus_addr)
      W_STATUS:  rd_mux = DATA_W'(status);
      W_PENDING: rd_mux = DATA_W'(pend);
      W_ENABLE:  rd_mux = DATA_W'(enable);
      W_VECTOR:  rd_mux = vec;
      W_MASTER:  rd_mux = DATA_W'(master);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_req   <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      irq_req   <= (&master) & (|pend);
    end
  end

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past((&master) && (|pend)));
  // R7
  vec_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (vec != '1) |-> (pend[vec[IDX_W-1:0]] && vec < NUM_IN));
  // R7
  vec_none_chk: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |-> (vec != '1));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int N = 8;
  logic clk = 0, rst = 1;
  logic [2:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [N-1:0] irq_src = 0;
  logic irq_req;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl #(.NUM_IN(N), .KIND_MASK(32'h0000_00F0)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .irq_req(irq_req));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk);
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(posedge clk);
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pulse(input int i);
    @(negedge clk); irq_src[i] = 1;
    @(negedge clk); irq_src[i] = 0;
  endtask

  task automatic t_reset;
    check("R1 irq", {31'd0, irq_req}, 0);
    rd_chk("R1 status", 0, 0);
    rd_chk("R1 enable", 2, 0);
    rd_chk("R1 master", 7, 0);
    rd_chk("R1 vector", 6, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge;
    @(negedge clk); irq_src[5] = 1;
    rd_chk("R8 edge latched", 0, 32'h20);
    wr(3, 32'h20);
    rd_chk("R8 held high no refire", 0, 0);
    @(negedge clk); irq_src[5] = 0;
    pulse(5);
    rd_chk("R8 new edge", 0, 32'h20);
    wr(3, 32'hFFFF_FFFF);
    rd_chk("R6 ack all", 0, 0);
  endtask

  task automatic t_level;
    @(negedge clk); irq_src[2] = 1;
    rd_chk("R9 level latched", 0, 32'h04);
    wr(3, 32'h04);
    rd_chk("R9 refire while high", 0, 32'h04);
    @(negedge clk); irq_src[2] = 0;
    wr(3, 32'h04);
    rd_chk("R6 ack level after drop", 0, 0);
  endtask

  task automatic t_enable;
    wr(2, 32'h0F);
    rd_chk("R5 enable write", 2, 32'h0F);
    wr(4, 32'h30);
    rd_chk("R3 set-enable", 2, 32'h3F);
    wr(5, 32'h05);
    rd_chk("R4 clear-enable", 2, 32'h3A);
    rd_chk("R2 ack reads zero", 3, 0);
    rd_chk("R2 set reads zero", 4, 0);
    rd_chk("R2 clr reads zero", 5, 0);
    wr(2, 32'hFFFF_FFFF);
    rd_chk("R5 upper bits dropped", 2, 32'hFF);
    wr(2, 0);
    rd_chk("R5 write zero", 2, 0);
  endtask

  task automatic t_vector;
    wr(2, 32'hFF);
    pulse(6);
    pulse(4);
    rd_chk("R2 pending", 1, 32'h50);
    rd_chk("R7 lowest", 6, 4);
    wr(3, 32'h10);
    rd_chk("R7 next", 6, 6);
    wr(5, 32'h40);
    rd_chk("R7 none enabled", 6, 32'hFFFF_FFFF);
    rd_chk("R2 pending masked", 1, 0);
    rd_chk("R2 status kept", 0, 32'h40);
  endtask

  task automatic t_irq;
    wr(4, 32'h40);
    wr(7, 32'h1);
    @(posedge clk); @(negedge clk);
    check("R10 only bit0", {31'd0, irq_req}, 0);
    wr(7, 32'h3);
    check("R10 not before latency", {31'd0, irq_req}, 0);
    @(posedge clk); @(negedge clk);
    check("R10 asserted", {31'd0, irq_req}, 1);
    rd_chk("R11 master read", 7, 3);
    wr(7, 32'h2);
    @(posedge clk); @(negedge clk);
    check("R10 only bit1", {31'd0, irq_req}, 0);
    wr(7, 32'h3);
    wr(3, 32'h40);
    @(posedge clk); @(negedge clk);
    check("R10 low after ack", {31'd0, irq_req}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_edge();
        t_level();
        t_enable();
        t_vector();
        t_irq();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule